// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter that uses three signal wires plus a power-down pin. One start request runs one full transaction. Chip-select goes low, which starts the conversion. The serial clock stays idle until the converter signals that it has finished. The controller then clocks out a marker bit and twelve data bits, MSB first. It captures data on the rising clock edge, and the converter moves its data on the falling edge. The controller returns the 12-bit word with a one-cycle valid strobe.

The end of conversion comes from one of two sources, chosen by `eoc_mode_i`. In watch mode the controller looks for the converter pulling its data line high. In fixed mode it waits a programmed number of cycles. In watch mode the same count acts as a timeout, which sets a sticky flag and ends the transaction without a result. Every timing value is a count of system-clock cycles supplied on an input:

- the serial clock phase length
- the maximum conversion wait
- the minimum chip-select high time after a normal read
- the recovery time after an abort or timeout
- the wake-up time after power-down

The states are Sleep, Wake, Ready, Convert, Readout and Gap. Named transitions:
- Sleep→Wake: power-down released.
- Wake→Ready: wake count elapsed.
- Wake→Sleep, Ready→Sleep: power-down requested.
- Ready→Convert: start.
- Convert→Readout: data line high (watch mode) or wait elapsed (fixed mode).
- Convert→Gap: abort, or timeout in watch mode.
- Readout→Gap: last falling serial-clock edge.
- Gap→Ready: gap count elapsed.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset the controller is in Sleep with `adc_cs_n`=1, `adc_sclk`=0, `adc_shdn_n`=0, `busy_o`=1, `valid_o`=0 and `timeout_o`=0.
- R2: While `pwr_down_i`=1 in Sleep or Ready, `adc_shdn_n` is 0 and `start_i` is ignored (`adc_cs_n` stays 1). After `pwr_down_i` is released, `busy_o` stays 1 for at least `wake_i` cycles before a start is accepted.
- R3: A start accepted in Ready drives `adc_cs_n` low on the next clock edge. `adc_sclk` stays 0 for the whole Convert state.
- R4: In watch mode (`eoc_mode_i`=1), serial clocking begins only after `adc_dout` is seen high, so the first rising serial-clock edge samples the marker value 1.
- R5: In fixed mode (`eoc_mode_i`=0), `adc_dout` is ignored during Convert. The first rising serial-clock edge comes no earlier than `conv_wait_i`+1 cycles after chip-select falls.
- R6: Readout issues 13+`extra_i` full serial-clock periods. The value on the 2nd through 13th rising edges forms `result_o[11]` down to `result_o[0]`. The first rising edge (the marker) is not stored.
- R7: Bits sampled on rising edges after the 13th do not change `result_o`.
- R8: Every serial-clock high and low phase during Readout lasts exactly max(`div_i`,1) system-clock cycles.
- R9: On the cycle after the last falling serial-clock edge, `adc_cs_n` is 1 and `valid_o` pulses for one cycle with the new `result_o`.
- R10: After a completed read, `adc_cs_n` stays high for at least `cs_high_i`+1 cycles, and `start_i` is ignored during that gap.
- R11: `abort_i`=1 during Convert raises `adc_cs_n` on the next edge, produces no `valid_o`, and holds chip-select high for at least `acq_i`+1 cycles.
- R12: In watch mode, if `conv_wait_i` cycles pass without `adc_dout` going high, `timeout_o` is set and the transaction ends as an abort. It has no `valid_o` and uses the `acq_i` recovery. `timeout_o` stays set until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one transaction (taken in Ready) |
| abort_i | input | 1 | Cancel a conversion in progress |
| pwr_down_i | input | 1 | Hold the converter powered down |
| eoc_mode_i | input | 1 | 1: watch data line; 0: fixed wait |
| div_i | input | 8 | Serial clock phase length in cycles (0 counts as 1) |
| extra_i | input | 4 | Serial clock periods appended after the 13th |
| conv_wait_i | input | 16 | Conversion wait / timeout count |
| cs_high_i | input | 16 | Chip-select high gap after a read |
| acq_i | input | 16 | Recovery gap after abort or timeout |
| wake_i | input | 16 | Wake-up count after power-down release |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_shdn_n | output | 1 | Converter power-down, active low |
| adc_dout | input | 1 | Serial data from converter |
| busy_o | output | 1 | High whenever not in Ready |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | Sticky end-of-conversion timeout flag |
| result_o | output | 12 | Last captured conversion word |

## Verification
The hardest situations to reach from the ports are the short windows around the end of a transaction. One is a start request that arrives during the post-read gap. The others are the recovery after an abort or a timeout, which must use the longer acquisition count rather than the chip-select gap. The stimulus reaches the first window by waiting for the valid strobe and pulsing start on the very next cycle. It reaches the others by starting the next transaction the moment busy drops and measuring how long chip-select stayed high. A converter model in the bench can withhold its marker indefinitely to force the timeout. The same model can be run in fixed mode to show that the data line is ignored.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_WAKE    = 3'd1,
        ST_READY   = 3'd2,
        ST_CONVERT = 3'd3,
        ST_READOUT = 3'd4,
        ST_GAP     = 3'd5
    } rd_state_e;

endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
// Saturating interval counter: done once the count reaches the limit.
module adc_rd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_sclk_gen.sv
`timescale 1ns/1ps
// Serial clock generator: each phase lasts max(div,1) system cycles.
module adc_rd_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] div_eff;
    logic             tick;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign tick    = en && (ph_q == div_eff - 1'b1);
    assign rise    = tick && !sclk;
    assign fall    = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            ph_q <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            ph_q <= '0;
            sclk <= ~sclk;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
`timescale 1ns/1ps
// MSB-first receive shifter.
module adc_rd_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic         din,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (cap) begin
            data <= {data[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_read_ctrl.sv
`timescale 1ns/1ps
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int DIV_W   = 8,
    parameter int CNT_W   = 16,
    parameter int EXTRA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic               pwr_down_i,
    input  logic               eoc_mode_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [EXTRA_W-1:0] extra_i,
    input  logic [CNT_W-1:0]   conv_wait_i,
    input  logic [CNT_W-1:0]   cs_high_i,
    input  logic [CNT_W-1:0]   acq_i,
    input  logic [CNT_W-1:0]   wake_i,
    output logic               adc_cs_n,
    output logic               adc_sclk,
    output logic               adc_shdn_n,
    input  logic               adc_dout,
    output logic               busy_o,
    output logic               valid_o,
    output logic               timeout_o,
    output logic [DATA_W-1:0]  result_o
);
    // Falling-edge counter must reach DATA_W + max extra
    localparam int FCNT_W = $clog2(DATA_W + (1 << EXTRA_W) + 1) + 1;
    localparam logic [FCNT_W-1:0] LAST_BASE = FCNT_W'(DATA_W);

    rd_state_e state_q, state_d;
    logic               to_evt;
    logic [CNT_W-1:0]   gap_q;
    logic               tmr_clr;
    logic [CNT_W-1:0]   tmr_lim;
    logic               tmr_done;
    logic               sclk_en;
    logic               sclk_rise;
    logic               sclk_fall;
    logic [FCNT_W-1:0]  fall_cnt;
    logic [FCNT_W-1:0]  last_idx;
    logic               last_fall;
    logic               cap;
    logic [DATA_W-1:0]  rx_data;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        to_evt  = 1'b0;
        unique case (state_q)
            ST_SLEEP: begin
                if (!pwr_down_i) state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (pwr_down_i)    state_d = ST_SLEEP;
                else if (tmr_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (pwr_down_i)   state_d = ST_SLEEP;
                else if (start_i) state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (abort_i) begin
                    state_d = ST_GAP;
                end else if (eoc_mode_i && adc_dout) begin
                    state_d = ST_READOUT;
                end else if (tmr_done) begin
                    if (eoc_mode_i) begin
                        state_d = ST_GAP;
                        to_evt  = 1'b1;
                    end else begin
                        state_d = ST_READOUT;
                    end
                end
            end
            ST_READOUT: begin
                if (last_fall) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (tmr_done) state_d = ST_READY;
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        adc_cs_n   = !((state_q == ST_CONVERT) || (state_q == ST_READOUT));
        adc_shdn_n = (state_q != ST_SLEEP);
        busy_o     = (state_q != ST_READY);
        sclk_en    = (state_q == ST_READOUT);
        unique case (state_q)
            ST_WAKE:    tmr_lim = wake_i;
            ST_CONVERT: tmr_lim = conv_wait_i;
            ST_GAP:     tmr_lim = gap_q;
            default:    tmr_lim = '0;
        endcase
    end

    assign tmr_clr   = (state_d != state_q);
    assign last_idx  = LAST_BASE + {{(FCNT_W-EXTRA_W){1'b0}}, extra_i};
    assign last_fall = sclk_fall && (fall_cnt == last_idx);
    assign cap       = sclk_rise && (fall_cnt != '0) && (fall_cnt <= LAST_BASE);

    // ---------------- sub-blocks ----------------
    adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_lim),
        .done  (tmr_done)
    );

    adc_rd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sclk_en),
        .div   (div_i),
        .sclk  (adc_sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    adc_rd_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (adc_dout),
        .data  (rx_data)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_cnt  <= '0;
            gap_q     <= '0;
            valid_o   <= 1'b0;
            result_o  <= '0;
            timeout_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_READOUT) begin
                if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
            end else begin
                fall_cnt <= '0;
            end
            if ((state_d == ST_GAP) && (state_q != ST_GAP)) begin
                gap_q <= (state_q == ST_READOUT) ? cs_high_i : acq_i;
            end
            if (last_fall) begin
                result_o <= rx_data;
                valid_o  <= 1'b1;
            end
            if (to_evt) begin
                timeout_o <= 1'b1;
            end else if ((state_q == ST_READY) && (state_d == ST_CONVERT)) begin
                timeout_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_read_ctrl_chk.sv
`timescale 1ns/1ps
module adc_read_ctrl_chk
    import adc_rd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rd_state_e state,
    input logic      abort_i,
    input logic      adc_cs_n,
    input logic      adc_sclk,
    input logic      adc_shdn_n,
    input logic      valid_o
);
    // R3
    sclk_quiet_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT) |-> !adc_sclk);

    // R9
    valid_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (adc_cs_n && !adc_sclk));

    // R2
    shdn_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_shdn_n |-> adc_cs_n);

    // R10
    cs_min_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |=> adc_cs_n);

    // R11
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CONVERT) && abort_i) |=> (adc_cs_n && !valid_o));

    // R6
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> (!adc_cs_n && (state == ST_READOUT)));
endmodule

bind adc_read_ctrl adc_read_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .abort_i    (abort_i),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .adc_shdn_n (adc_shdn_n),
    .valid_o    (valid_o)
);

// File: tb/adc_read_ctrl_tb.sv
`timescale 1ns/1ps
module adc_read_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, abort_i = 1'b0, pwr_down_i = 1'b1, eoc_mode_i = 1'b1;
    logic [7:0]  div_i = 8'd2;
    logic [3:0]  extra_i = 4'd0;
    logic [15:0] conv_wait_i = 16'd60, cs_high_i = 16'd3, acq_i = 16'd20, wake_i = 16'd12;
    logic        adc_cs_n, adc_sclk, adc_shdn_n, busy_o, valid_o, timeout_o;
    logic        adc_dout = 1'b0;
    logic [11:0] result_o;

    always #2 clk = ~clk;   // 250 MHz

    adc_read_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .pwr_down_i(pwr_down_i), .eoc_mode_i(eoc_mode_i), .div_i(div_i),
        .extra_i(extra_i), .conv_wait_i(conv_wait_i), .cs_high_i(cs_high_i),
        .acq_i(acq_i), .wake_i(wake_i), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_shdn_n(adc_shdn_n), .adc_dout(adc_dout), .busy_o(busy_o),
        .valid_o(valid_o), .timeout_o(timeout_o), .result_o(result_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [11:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [11:0] model_data = '0;
    int          conv_dly = 10;
    int          m_cyc = 0, m_fall = 0;
    logic        m_sclk_prev = 1'b0;

    always @(posedge clk) begin
        #1;
        if (adc_cs_n) begin
            adc_dout = 1'b0;
            m_cyc    = 0;
            m_fall   = 0;
        end else begin
            m_cyc++;
            if (m_sclk_prev && !adc_sclk) begin
                m_fall++;
                adc_dout = (m_fall <= 12) ? model_data[12-m_fall] : 1'b0;
            end else if (m_fall == 0 && m_cyc == conv_dly) begin
                adc_dout = 1'b1;
            end
        end
        m_sclk_prev = adc_sclk;
    end

    // ---------------- monitor ----------------
    int   hi_run = 0, last_gap = 0, conv_cyc = 0, falls = 0;
    int   ph_len = 0, ph_min = 0, ph_max = 0;
    bit   first_rise = 0, marker = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!adc_cs_n && prev_cs) begin
                last_gap   = hi_run;
                hi_run     = 0;
                conv_cyc   = 0;
                falls      = 0;
                ph_len     = 0;
                ph_min     = 9999;
                ph_max     = 0;
                first_rise = 0;
            end
            if (adc_cs_n) hi_run++;
            if (adc_sclk != prev_sclk) begin
                if (first_rise) begin
                    if (ph_len < ph_min) ph_min = ph_len;
                    if (ph_len > ph_max) ph_max = ph_len;
                end
                ph_len = 1;
            end else begin
                ph_len++;
            end
            if (!adc_cs_n && !first_rise) begin
                if (adc_sclk) begin
                    first_rise = 1;
                    marker     = adc_dout;
                end else begin
                    conv_cyc++;
                end
            end
            if (prev_sclk && !adc_sclk) falls++;
            if (valid_o) begin
                chk(adc_cs_n == 1'b1, "R9 cs high at valid", int'(adc_cs_n), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11/R12 unexpected valid", int'(result_o), -1);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    chk(result_o == e, "R6 result word", int'(result_o), int'(e));
                end
            end
            prev_sclk = adc_sclk;
            prev_cs   = adc_cs_n;
        end
    end

    // ---------------- helpers ----------------
    int exp_gap = 0;
    string gap_tag = "R10";

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic do_conv(input logic [11:0] d, input int dly, input logic [7:0] dv,
                           input logic [3:0] ex, input bit mode, input int w);
        int eff;
        eff = (dv == 0) ? 1 : int'(dv);
        model_data = d; conv_dly = dly;
        div_i = dv; extra_i = ex; eoc_mode_i = mode; conv_wait_i = 16'(w);
        exp_q.push_back(d);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(!adc_cs_n && !adc_sclk, "R3 cs low, sclk idle after start", int'(adc_cs_n), 0);
        chk(timeout_o == 1'b0, "R12 flag cleared on start", int'(timeout_o), 0);
        @(negedge clk);
        chk(last_gap >= exp_gap, {gap_tag, " chip-select high gap"}, last_gap, exp_gap);
        wait_idle();
        chk(exp_q.size() == 0, "R6 result delivered", exp_q.size(), 0);
        chk(falls == 13 + int'(ex), (ex == 0) ? "R6 falling edges" : "R7 falling edges",
            falls, 13 + int'(ex));
        chk(ph_min == eff && ph_max == eff, "R8 phase length", ph_max, eff);
        if (mode) chk(marker == 1'b1, "R4 marker at first rise", int'(marker), 1);
        else      chk(conv_cyc >= w + 1, "R5 fixed wait", conv_cyc, w + 1);
        exp_gap = int'(cs_high_i) + 1;
        gap_tag = "R10";
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        bit   saw_low;
        int   busy_cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(adc_cs_n && !adc_sclk && !adc_shdn_n, "R1 reset pins", int'({adc_cs_n, adc_sclk, adc_shdn_n}), 4);
        chk(busy_o && !valid_o && !timeout_o, "R1 reset flags", int'({busy_o, valid_o, timeout_o}), 4);

        // R2: start ignored while asleep
        pulse_start();
        saw_low = 0;
        repeat (8) begin @(negedge clk); if (!adc_cs_n) saw_low = 1; end
        chk(!saw_low && !adc_shdn_n, "R2 start ignored in sleep", int'(saw_low), 0);

        // R2: wake-up hold-off
        pwr_down_i = 1'b0;
        busy_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy_o) break;
            busy_cnt++;
        end
        chk(busy_cnt >= int'(wake_i) && adc_shdn_n, "R2 wake delay", busy_cnt, int'(wake_i));

        // Normal watch-mode reads, several patterns and dividers
        do_conv(12'hABC, 10, 8'd2, 4'd0, 1'b1, 60);
        do_conv(12'h000, 5, 8'd1, 4'd0, 1'b1, 60);
        do_conv(12'hFFF, 20, 8'd3, 4'd0, 1'b1, 60);
        do_conv(12'h5A3, 8, 8'd0, 4'd0, 1'b1, 60);
        // R5: fixed mode, converter never raises its marker
        do_conv(12'h3C9, 100000, 8'd2, 4'd0, 1'b0, 40);
        // R7: extra clocks produce zeros that must not enter the result
        do_conv(12'h9E1, 6, 8'd2, 4'd5, 1'b1, 60);

        // R11: abort during conversion
        model_data = 12'h777; conv_dly = 50; eoc_mode_i = 1'b1; conv_wait_i = 16'd60;
        pulse_start();
        repeat (6) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk(adc_cs_n == 1'b1, "R11 cs released on abort", int'(adc_cs_n), 1);
        wait_idle();
        chk(falls == 0 && !timeout_o, "R11 no readout after abort", falls, 0);
        exp_gap = int'(acq_i) + 1; gap_tag = "R11";
        do_conv(12'h1E4, 9, 8'd2, 4'd0, 1'b1, 60);

        // R12: timeout in watch mode
        model_data = 12'h222; conv_dly = 100000; eoc_mode_i = 1'b1; conv_wait_i = 16'd30;
        pulse_start();
        wait_idle();
        chk(timeout_o == 1'b1, "R12 timeout flag set", int'(timeout_o), 1);
        chk(falls == 0, "R12 no clocking after timeout", falls, 0);
        repeat (3) @(negedge clk);
        chk(timeout_o == 1'b1, "R12 timeout flag sticky", int'(timeout_o), 1);
        exp_gap = int'(acq_i) + 1; gap_tag = "R12";
        do_conv(12'h8C5, 7, 8'd1, 4'd0, 1'b1, 60);

        // R10: start pulsed inside the post-read gap is ignored
        cs_high_i = 16'd10;
        model_data = 12'h4B2; conv_dly = 6; div_i = 8'd1; extra_i = 4'd0;
        exp_q.push_back(12'h4B2);
        pulse_start();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (valid_o) break;
        end
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        saw_low = 0;
        repeat (25) begin @(negedge clk); if (!adc_cs_n) saw_low = 1; end
        chk(!saw_low, "R10 start ignored in gap", int'(saw_low), 0);
        chk(exp_q.size() == 0, "R6 gap-test result delivered", exp_q.size(), 0);

        // R2: power down from Ready, start ignored, then wake again
        pwr_down_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(adc_shdn_n == 1'b0, "R2 shutdown driven", int'(adc_shdn_n), 0);
        pulse_start();
        saw_low = 0;
        repeat (6) begin @(negedge clk); if (!adc_cs_n) saw_low = 1; end
        chk(!saw_low, "R2 start ignored while down", int'(saw_low), 0);
        pwr_down_i = 1'b0;
        busy_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy_o) break;
            busy_cnt++;
        end
        chk(busy_cnt >= int'(wake_i), "R2 wake delay again", busy_cnt, int'(wake_i));
        exp_gap = 0;
        do_conv(12'h6D0, 12, 8'd2, 4'd1, 1'b1, 60);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule